// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block keeps the interrupt state of a storage adapter: a 64-bit cause register and a 64-bit enable register. Two internal sources feed the cause register. A completion publish strobe sets the completion cause bit, but only when the batch actually posted work. A message event sets the message cause bit. Software reads either register through a select input, acknowledges causes by writing ones to the cause register, and loads the enable register with a whole-word write. The register-bus decode lives outside the block; only a write strobe, a register select and the write data arrive here.

The block drives its request in one of two ways, chosen by the `msi_en` input. In level mode, `irq_level` always tracks whether any enabled cause is pending. In message mode, `irq_level` is frozen and a one-clock `msi_pulse` fires each time the condition is re-evaluated and found true. A re-evaluation happens on a cause write, an enable write, a qualifying completion publish or a message event. Each cause write made while completed work is still queued also produces a one-clock `cmp_retry` request, so that the completion path posts again. An adapter reset input clears the causes but leaves the enable register alone.

Top module: `irq_status_ctrl`

## Requirements
- R1: After `rst_n` is sampled low, the cause register, the enable register, `irq_level`, `msi_pulse` and `cmp_retry` are all zero.
- R2: A write with `reg_sel`=1 replaces all 64 bits of the enable register at the next edge. `reg_rdata` shows the enable register while `reg_sel`=1 and the cause register while `reg_sel`=0, with no added delay.
- R3: A write with `reg_sel`=0 clears exactly those cause bits that are one in `reg_wdata` and keeps every other bit.
- R4: `cmp_publish` sets cause bit 0 when `cmp_posted` is nonzero. With `cmp_posted` equal to zero the publish has no effect.
- R5: `msg_event` sets cause bit 12.
- R6: While `msi_en` is 0, `irq_level` equals the OR of (cause AND enable), and it is updated at the same edge as the registers.
- R7: While `msi_en` is 1, each re-evaluation trigger (cause write, enable write, qualifying publish, message event) whose resulting condition is true gives `msi_pulse`=1 for exactly the following clock. `irq_level` keeps its value.
- R8: In message mode there is no pulse on a trigger whose resulting condition is false, and none in a cycle without a trigger, even if the condition stays true.
- R9: A cause write with `cmp_pending`=1 raises `cmp_retry` for one clock after the edge. A cause write without pending work, and an enable write, do not raise it.
- R10: `adapter_rst` clears the cause register at the next edge and leaves the enable register unchanged.
- R11: A cause set in the same cycle as a clearing write of that bit, or as `adapter_rst`, wins: the bit is one after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the cause register, 1 selects the enable register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |
| cmp_publish | input | 1 | Completion producer index published |
| cmp_posted | input | 8 | Number of completions posted in that batch |
| msg_event | input | 1 | Message descriptor posted |
| cmp_pending | input | 1 | Completed work is still queued |
| adapter_rst | input | 1 | Adapter reset: clear causes |
| msi_en | input | 1 | 1 selects message pulses, 0 selects the level line |
| irq_level | output | 1 | Level interrupt request |
| msi_pulse | output | 1 | One-clock message interrupt notify |
| cmp_retry | output | 1 | Request to retry completion posting |

## Verification
Two functions can act on the same cause bit in one cycle: a cause set from the completion or message path, and a clear from either a software acknowledge or an adapter reset. The bench provokes both kinds of collision on purpose, first as directed cycles and then through random stimulus that often lands a set next to a clear. Each case is judged against a behavioural model in which the set is applied last. The model is also checked on the pulse that such a collision produces in message mode.

// File: rtl/isc_pkg.sv
// Shared types for the interrupt status controller.
// Assumes: one register write per cycle, selected by a single select bit.
package isc_pkg;

    // Register select encoding on the write/read side
    typedef enum logic {
        ISC_SEL_CAUSE  = 1'b0,
        ISC_SEL_ENABLE = 1'b1
    } isc_sel_e;

    // Events that force a re-evaluation of the request condition
    typedef struct packed {
        logic cause_wr;
        logic enable_wr;
        logic cmp_set;
        logic msg_set;
    } isc_trig_t;

endpackage

// File: rtl/isc_cause_reg.sv
// Cause register: write-one-to-clear from software, adapter wipe, and
// set inputs from the completion and message paths.
// Assumes: sets are applied after clears so a simultaneous event is kept.
// Exposes the next-state value so the request logic sees the same edge.
module isc_cause_reg #(
    parameter int W       = 64,
    parameter int CMP_BIT = 0,
    parameter int MSG_BIT = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    input  logic         wipe,
    input  logic         set_cmp,
    input  logic         set_msg,
    output logic [W-1:0] cause_nx,
    output logic [W-1:0] cause_q
);

    logic [W-1:0] set_vec;
    logic [W-1:0] kept;

    // Build the set vector from the two event inputs
    always_comb begin
        set_vec          = '0;
        set_vec[CMP_BIT] = set_cmp;
        set_vec[MSG_BIT] = set_msg;
    end

    // Apply wipe, then software clear, then the event sets
    always_comb begin
        kept = wipe ? '0 : cause_q;
        if (clr_en) begin
            kept = kept & ~clr_mask;
        end
        cause_nx = kept | set_vec;
    end

    // Hold the cause register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= cause_nx;
        end
    end

endmodule

// File: rtl/isc_enable_reg.sv
// Enable register: whole-word load from software; untouched by adapter reset.
// Assumes: only the chip reset clears it.
module isc_enable_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] enable_nx,
    output logic [W-1:0] enable_q
);

    // Select the value the register takes at the next edge
    always_comb begin
        enable_nx = load ? load_data : enable_q;
    end

    // Hold the enable register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else begin
            enable_q <= enable_nx;
        end
    end

endmodule

// File: rtl/isc_irq_drive.sv
// Request driver: evaluates (cause AND enable) on the next-state values,
// drives a level line in level mode or one-clock notify pulses in message mode.
// Assumes: LANE_W divides the reduction into lanes; a partial top lane is padded.
module isc_irq_drive
    import isc_pkg::*;
#(
    parameter int W      = 64,
    parameter int LANE_W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cause_nx,
    input  logic [W-1:0] enable_nx,
    input  isc_trig_t    trig,
    input  logic         msi_en,
    output logic         irq_level,
    output logic         msi_pulse
);

    localparam int NLANE = (W + LANE_W - 1) / LANE_W;
    localparam int PAD_W = NLANE * LANE_W;

    logic [PAD_W-1:0] hit_pad;
    logic [NLANE-1:0] lane_hit;
    logic             cond;
    logic             reeval;

    // Pad the masked cause vector to whole lanes
    always_comb begin
        hit_pad          = '0;
        hit_pad[W-1:0]   = cause_nx & enable_nx;
    end

    // One OR reduction per lane
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_hit[g] = |hit_pad[g*LANE_W +: LANE_W];
    end

    // Combine lanes and detect a re-evaluation trigger
    always_comb begin
        cond   = |lane_hit;
        reeval = trig.cause_wr | trig.enable_wr | trig.cmp_set | trig.msg_set;
    end

    // Register the level line and the notify pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level <= 1'b0;
            msi_pulse <= 1'b0;
        end else begin
            msi_pulse <= msi_en & reeval & cond;
            if (!msi_en) begin
                irq_level <= cond;
            end
        end
    end

endmodule

// File: rtl/isc_retry_gen.sv
// Retry request: an acknowledge while completed work is queued asks the
// completion path to post again, one clock after the write.
module isc_retry_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_wr,
    input  logic work_queued,
    output logic retry
);

    // Register the one-clock retry request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry <= 1'b0;
        end else begin
            retry <= ack_wr & work_queued;
        end
    end

endmodule

// File: rtl/irq_status_ctrl.sv
// Top of the interrupt status controller: decodes the write strobe onto the
// cause and enable registers, qualifies completion publishes, drives the
// request outputs and the completion retry request, and muxes read data.
// Assumes: register-bus decode is external; reads are combinational.
module irq_status_ctrl
    import isc_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int CNT_W   = 8,
    parameter int CMP_BIT = 0,
    parameter int MSG_BIT = 12,
    parameter int LANE_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cmp_publish,
    input  logic [CNT_W-1:0]  cmp_posted,
    input  logic              msg_event,
    input  logic              cmp_pending,
    input  logic              adapter_rst,
    input  logic              msi_en,
    output logic              irq_level,
    output logic              msi_pulse,
    output logic              cmp_retry
);

    isc_sel_e          sel;
    isc_trig_t         trig;
    logic [DATA_W-1:0] cause_nx;
    logic [DATA_W-1:0] cause_q;
    logic [DATA_W-1:0] enable_nx;
    logic [DATA_W-1:0] enable_q;

    // Decode the write strobe and qualify the completion publish
    always_comb begin
        sel            = isc_sel_e'(reg_sel);
        trig.cause_wr  = reg_wr && (sel == ISC_SEL_CAUSE);
        trig.enable_wr = reg_wr && (sel == ISC_SEL_ENABLE);
        trig.cmp_set   = cmp_publish && (cmp_posted != '0);
        trig.msg_set   = msg_event;
    end

    isc_cause_reg #(
        .W       (DATA_W),
        .CMP_BIT (CMP_BIT),
        .MSG_BIT (MSG_BIT)
    ) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (trig.cause_wr),
        .clr_mask (reg_wdata),
        .wipe     (adapter_rst),
        .set_cmp  (trig.cmp_set),
        .set_msg  (trig.msg_set),
        .cause_nx (cause_nx),
        .cause_q  (cause_q)
    );

    isc_enable_reg #(
        .W (DATA_W)
    ) u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (trig.enable_wr),
        .load_data (reg_wdata),
        .enable_nx (enable_nx),
        .enable_q  (enable_q)
    );

    isc_irq_drive #(
        .W      (DATA_W),
        .LANE_W (LANE_W)
    ) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause_nx  (cause_nx),
        .enable_nx (enable_nx),
        .trig      (trig),
        .msi_en    (msi_en),
        .irq_level (irq_level),
        .msi_pulse (msi_pulse)
    );

    isc_retry_gen u_retry (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_wr      (trig.cause_wr),
        .work_queued (cmp_pending),
        .retry       (cmp_retry)
    );

    // Read mux over the two registers
    always_comb begin
        reg_rdata = (sel == ISC_SEL_ENABLE) ? enable_q : cause_q;
    end

endmodule

// File: rtl/isc_checker.sv
// Property checker for the interrupt status controller, bound to the top.
module isc_checker #(
    parameter int W       = 64,
    parameter int CNT_W   = 8,
    parameter int CMP_BIT = 0,
    parameter int MSG_BIT = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic [W-1:0]     reg_wdata,
    input logic             cmp_publish,
    input logic [CNT_W-1:0] cmp_posted,
    input logic             msg_event,
    input logic             cmp_pending,
    input logic             adapter_rst,
    input logic             msi_en,
    input logic             irq_level,
    input logic             msi_pulse,
    input logic             cmp_retry,
    input logic [W-1:0]     cause_q,
    input logic [W-1:0]     enable_q
);

    logic [W-1:0] cause_mask;
    always_comb begin
        cause_mask          = '0;
        cause_mask[CMP_BIT] = 1'b1;
        cause_mask[MSG_BIT] = 1'b1;
    end

    // R2: without an enable write the enable register holds
    assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_sel) |=> $stable(enable_q));

    // R3: a pure acknowledge leaves none of the written bits set
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && !cmp_publish && !msg_event)
        |=> ((cause_q & $past(reg_wdata)) == '0));

    // R4: a qualifying publish sets the completion cause
    assert_cmp_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_publish && (cmp_posted != '0)) |=> cause_q[CMP_BIT]);

    // R5: a message event sets the message cause
    assert_msg_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_event |=> cause_q[MSG_BIT]);

    // R6: in level mode the line mirrors the masked causes
    assert_level_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(msi_en)) |-> (irq_level == |(cause_q & enable_q)));

    // R7: in message mode the level line is frozen
    assert_level_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(msi_en)) |-> $stable(irq_level));

    // R8: a pulse only comes from message mode with an enabled cause pending
    assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse |-> ($past(msi_en) && ((cause_q & enable_q) != '0)));

    // R9: retry only follows an acknowledge with queued work
    assert_retry_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_retry |-> ($past(rst_n) && $past(reg_wr && !reg_sel && cmp_pending)));

    // R10: adapter reset leaves at most freshly set cause bits
    assert_adapter_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        adapter_rst |=> ((cause_q & ~cause_mask) == '0));

    // R11: a message set survives a same-cycle acknowledge of its bit
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && reg_wdata[MSG_BIT] && msg_event) |=> cause_q[MSG_BIT]);

endmodule

bind irq_status_ctrl isc_checker #(
    .W       (DATA_W),
    .CNT_W   (CNT_W),
    .CMP_BIT (CMP_BIT),
    .MSG_BIT (MSG_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .cmp_publish (cmp_publish),
    .cmp_posted  (cmp_posted),
    .msg_event   (msg_event),
    .cmp_pending (cmp_pending),
    .adapter_rst (adapter_rst),
    .msi_en      (msi_en),
    .irq_level   (irq_level),
    .msi_pulse   (msi_pulse),
    .cmp_retry   (cmp_retry),
    .cause_q     (cause_q),
    .enable_q    (enable_q)
);

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        cmp_publish = 1'b0;
    logic [7:0]  cmp_posted = '0;
    logic        msg_event = 1'b0;
    logic        cmp_pending = 1'b0;
    logic        adapter_rst = 1'b0;
    logic        msi_en = 1'b0;
    logic        irq_level;
    logic        msi_pulse;
    logic        cmp_retry;

    int checks = 0;
    int failures = 0;
    bit started = 0;
    bit msi_mode = 0;

    // Reference model state
    logic [63:0] m_cause = '0;
    logic [63:0] m_enable = '0;
    logic        m_level = 0;
    logic        m_pulse = 0;
    logic        m_retry = 0;

    always #4 clk = ~clk;

    irq_status_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_publish(cmp_publish),
        .cmp_posted(cmp_posted), .msg_event(msg_event), .cmp_pending(cmp_pending),
        .adapter_rst(adapter_rst), .msi_en(msi_en), .irq_level(irq_level),
        .msi_pulse(msi_pulse), .cmp_retry(cmp_retry)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural model: set applied after clears, condition on new values
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cause = '0; m_enable = '0; m_level = 0; m_pulse = 0; m_retry = 0;
        end else begin
            logic cset;
            logic trig;
            logic cond;
            cset = cmp_publish && (cmp_posted != 0);
            trig = reg_wr || cset || msg_event;
            if (adapter_rst) m_cause = '0;
            if (reg_wr && !reg_sel) m_cause = m_cause & ~reg_wdata;
            if (cset) m_cause[0] = 1'b1;
            if (msg_event) m_cause[12] = 1'b1;
            if (reg_wr && reg_sel) m_enable = reg_wdata;
            cond = (m_cause & m_enable) != 0;
            m_pulse = msi_en && trig && cond;
            if (!msi_en) m_level = cond;
            m_retry = reg_wr && !reg_sel && cmp_pending;
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started && rst_n) begin
            chk(reg_rdata, reg_sel ? m_enable : m_cause, "R2/R3 model rdata");
            chk({63'b0, irq_level}, {63'b0, m_level}, "R6 model irq_level");
            chk({63'b0, msi_pulse}, {63'b0, m_pulse}, "R7 model msi_pulse");
            chk({63'b0, cmp_retry}, {63'b0, m_retry}, "R9 model cmp_retry");
        end
    end

    // Drive one cycle of stimulus; returns at the following compare point
    task automatic drive(input logic wr, input logic sel, input logic [63:0] wd,
                         input logic pub, input logic [7:0] cnt, input logic msg,
                         input logic pend, input logic arst);
        #2;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd; cmp_publish = pub;
        cmp_posted = cnt; msg_event = msg; cmp_pending = pend;
        adapter_rst = arst; msi_en = msi_mode;
        @(negedge clk);
    endtask

    task automatic idle(input logic sel);
        drive(0, sel, 64'h0, 0, 8'd0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        started = 1;

        // R1: reset state
        idle(0);
        chk(reg_rdata, 64'h0, "R1 cause after reset");
        chk({63'b0, irq_level}, 64'h0, "R1 irq_level");
        chk({63'b0, msi_pulse}, 64'h0, "R1 msi_pulse");
        chk({63'b0, cmp_retry}, 64'h0, "R1 cmp_retry");
        idle(1);
        chk(reg_rdata, 64'h0, "R1 enable after reset");

        // R5: message cause, not enabled yet
        drive(0, 0, 64'h0, 0, 8'd0, 1, 0, 0);
        chk(reg_rdata, 64'h1000, "R5 message cause bit 12");
        chk({63'b0, irq_level}, 64'h0, "R6 level low while masked");

        // R2: enable load, R6 level rises
        drive(1, 1, 64'h1001, 0, 8'd0, 0, 0, 0);
        chk(reg_rdata, 64'h1001, "R2 enable readback");
        chk({63'b0, irq_level}, 64'h1, "R6 level high");

        // R4: empty publish ignored, nonempty publish sets bit 0
        drive(0, 0, 64'h0, 1, 8'd0, 0, 0, 0);
        chk(reg_rdata, 64'h1000, "R4 empty publish ignored");
        drive(0, 0, 64'h0, 1, 8'd3, 0, 0, 0);
        chk(reg_rdata, 64'h1001, "R4 publish sets bit 0");

        // R3 + R9: acknowledge with queued work
        drive(1, 0, 64'h1000, 0, 8'd0, 0, 1, 0);
        chk(reg_rdata, 64'h0001, "R3 only written bit cleared");
        chk({63'b0, cmp_retry}, 64'h1, "R9 retry after acknowledge");
        drive(1, 0, 64'h0001, 0, 8'd0, 0, 0, 0);
        chk(reg_rdata, 64'h0, "R3 clear bit 0");
        chk({63'b0, cmp_retry}, 64'h0, "R9 no retry without queued work");
        chk({63'b0, irq_level}, 64'h0, "R6 level falls");

        // R2: full-width enable with pending work gives no retry
        drive(1, 1, 64'hFFFF_0000_0000_1001, 0, 8'd0, 0, 1, 0);
        chk(reg_rdata, 64'hFFFF_0000_0000_1001, "R2 full 64-bit enable");
        chk({63'b0, cmp_retry}, 64'h0, "R9 enable write gives no retry");

        // R7/R8: message mode
        msi_mode = 1;
        drive(0, 0, 64'h0, 1, 8'd1, 0, 0, 0);
        chk({63'b0, msi_pulse}, 64'h1, "R7 pulse on completion");
        chk({63'b0, irq_level}, 64'h0, "R7 level frozen");
        idle(0);
        chk({63'b0, msi_pulse}, 64'h0, "R8 no pulse without trigger");
        drive(1, 1, 64'h0, 0, 8'd0, 0, 0, 0);
        chk({63'b0, msi_pulse}, 64'h0, "R8 no pulse when masked");
        drive(1, 1, 64'h1, 0, 8'd0, 0, 0, 0);
        chk({63'b0, msi_pulse}, 64'h1, "R7 pulse on enable write");

        // R11: set wins over same-cycle acknowledge
        drive(1, 0, 64'h1, 1, 8'd2, 0, 0, 0);
        chk(reg_rdata, 64'h1, "R11 set beats clear");
        chk({63'b0, msi_pulse}, 64'h1, "R7 pulse on collision");

        // R10: adapter reset
        drive(0, 0, 64'h0, 0, 8'd0, 0, 0, 1);
        chk(reg_rdata, 64'h0, "R10 cause cleared");
        idle(1);
        chk(reg_rdata, 64'h1, "R10 enable kept");
        drive(0, 0, 64'h0, 0, 8'd0, 1, 0, 1);
        chk(reg_rdata, 64'h1000, "R11 set beats adapter reset");
        drive(1, 0, 64'h1000, 0, 8'd0, 0, 0, 0);
        chk({63'b0, msi_pulse}, 64'h0, "R8 no pulse when false after ack");

        // Random phase against the model (R2..R11)
        msi_mode = 0;
        for (int i = 0; i < 600; i++) begin
            logic [63:0] wd;
            wd = {$urandom, $urandom};
            if ($urandom % 2 == 0) wd = wd & 64'h1001;
            if ($urandom % 23 == 0) msi_mode = ~msi_mode;
            drive(($urandom % 3) == 0, $urandom % 2, wd, ($urandom % 3) == 0,
                  8'($urandom % 4), ($urandom % 4) == 0, $urandom % 2,
                  ($urandom % 17) == 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule